// File: doc/BRIEF.md
# Command-Only Read Chunk Sequencer

This block turns one read command that arrives with no data beats into a train of burst-sized chunk requests. From the command byte count, or from the request's own length when the command count is zero, it works out how many bursts the read covers. After a fixed decode delay it issues one chunk per burst at consecutive burst-stride addresses. The chunks are spaced evenly across a drain window, which models the rate at which read data can leave through the slowest link.

Each chunk goes to a channel scheduler outside this block. The scheduler holds the per-channel availability and direction state, and it serves the write-beat path as well. For every chunk the scheduler answers with the number of cycles until that chunk's channel commit ends. The sequencer keeps the latest of these finish points. Once the last chunk has been answered, it waits until that point and then raises a one-cycle done pulse. The block handles one command at a time.

Top module: `read_chunk_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `cmd_ready_o` is 1, and `chk_valid_o` and `done_o` are 0.
- R2: The work size is `cmd_len_i` when that is non-zero. Otherwise it is `req_len_i`.
- R3: Exactly ceil(work / BURST_BYTES) chunk requests are issued per command, so a partial burst counts as one whole chunk.
- R4: A command whose work size is zero issues no chunk. Its done pulse appears in the cycle after edge P+OVH_CYC, where P is the edge that accepted the command.
- R5: Chunk k carries address base + k*BURST_BYTES and direction code `chk_wr_o` = 0, which means read.
- R6: The first chunk is valid in the cycle after edge P+OVH_CYC+G. G is the chunk gap of R7.
- R7: The gap G is 0 when the drain time is 0. Otherwise G is drain/chunk_count, truncated, with a minimum of 1. When the reply to chunk k is accepted on edge e, chunk k+1 is valid in the cycle after edge e+G. Each chunk request lasts exactly one cycle.
- R8: A reply (`fin_valid_i`) is accepted only while a chunk request is outstanding. A reply at any other time has no effect on the outputs or on the done timing.
- R9: Let e_k be the edge that accepts the reply to chunk k, and f_k the value of `fin_cyc_i` on that edge. `done_o` is a one-cycle pulse in the cycle after edge max(max_k(e_k+f_k), e_last+1).
- R10: `cmd_ready_o` is 0 from the accepting edge through the done cycle, and it is 1 again in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Sequencer idle, command accepted |
| cmd_addr_i | input | ADDR_W | Base byte address |
| cmd_len_i | input | LEN_W | Command byte count (0 for command-only reads) |
| req_len_i | input | LEN_W | Fallback request byte count |
| drain_cyc_i | input | DRAIN_W | Drain window in cycles |
| chk_valid_o | output | 1 | Chunk request, one cycle |
| chk_addr_o | output | ADDR_W | Chunk address |
| chk_wr_o | output | 1 | Direction code, 0 = read |
| fin_valid_i | input | 1 | Scheduler reply valid |
| fin_cyc_i | input | FIN_W | Cycles from the reply edge until the chunk's commit ends |
| done_o | output | 1 | Command complete pulse |

## Verification
The command patterns are chosen so that each one separates a different rule:
- An aligned multi-burst read with a wide drain window pins down the overhead, the gap arithmetic and the address stride.
- A fallback-length read with an unaligned base and a non-multiple length separates the use of the request length from the command length, and shows the rounding-up.
- A read with more chunks than drain cycles exercises the one-cycle minimum gap.
- A zero drain time shows back-to-back issue.
- An empty read shows the path that issues no chunk.

Two more patterns check the finish tracking. In the first, the first chunk's reply finishes later than all the later ones, which separates max-tracking from last-reply tracking. In the second, a stray reply sent while the block is idle must leave the following command's done timing unchanged.

// File: rtl/read_chunk_seq_pkg.sv
package read_chunk_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OVH,
    ST_GAP,
    ST_ISSUE,
    ST_REPLY,
    ST_DRAIN,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/rcs_plan.sv
module rcs_plan #(
  parameter int LEN_W       = 24,
  parameter int DRAIN_W     = 16,
  parameter int BURST_BYTES = 256,
  parameter int CNT_W       = 17
) (
  input  logic [LEN_W-1:0]   cmd_len_i,
  input  logic [LEN_W-1:0]   req_len_i,
  input  logic [DRAIN_W-1:0] drain_i,
  output logic [CNT_W-1:0]   n_chunks_o,
  output logic [DRAIN_W-1:0] gap_o
);
  localparam int BURST_SH = $clog2(BURST_BYTES);
  localparam int DIV_W    = (DRAIN_W > CNT_W) ? DRAIN_W : CNT_W;

  logic [LEN_W-1:0] work;
  logic [LEN_W:0]   work_rnd;
  logic [DIV_W-1:0] num, den, quo;

  assign work       = (cmd_len_i != '0) ? cmd_len_i : req_len_i;
  assign work_rnd   = {1'b0, work} + (LEN_W+1)'(BURST_BYTES - 1);
  assign n_chunks_o = work_rnd[LEN_W:BURST_SH];

  assign num = DIV_W'(drain_i);
  assign den = DIV_W'(n_chunks_o);
  assign quo = (den == '0) ? '0 : num / den;

  always_comb begin
    if (drain_i == '0 || n_chunks_o == '0) gap_o = '0;
    else if (quo == '0)                    gap_o = DRAIN_W'(1);
    else                                   gap_o = quo[DRAIN_W-1:0];
  end
endmodule

// File: rtl/rcs_fin_track.sv
module rcs_fin_track #(
  parameter int FIN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic [FIN_W-1:0] fin_i,
  output logic [FIN_W-1:0] rem_o,
  output logic             expire_o
);
  logic [FIN_W-1:0] rem_q, rem_dec;

  assign rem_dec  = (rem_q == '0) ? '0 : rem_q - FIN_W'(1);
  assign rem_o    = rem_q;
  assign expire_o = (rem_q <= FIN_W'(1));

  // rem_q counts down to the latest finish seen so far
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rem_q <= '0;
    else if (clr_i) rem_q <= '0;
    else if (upd_i) rem_q <= (fin_i > rem_dec) ? fin_i : rem_dec;
    else            rem_q <= rem_dec;
  end
endmodule

// File: rtl/read_chunk_seq.sv
module read_chunk_seq
  import read_chunk_seq_pkg::*;
#(
  parameter int ADDR_W      = 40,
  parameter int LEN_W       = 24,
  parameter int DRAIN_W     = 16,
  parameter int FIN_W       = 16,
  parameter int BURST_BYTES = 256,
  parameter int OVH_CYC     = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [ADDR_W-1:0]  cmd_addr_i,
  input  logic [LEN_W-1:0]   cmd_len_i,
  input  logic [LEN_W-1:0]   req_len_i,
  input  logic [DRAIN_W-1:0] drain_cyc_i,
  output logic               chk_valid_o,
  output logic [ADDR_W-1:0]  chk_addr_o,
  output logic               chk_wr_o,
  input  logic               fin_valid_i,
  input  logic [FIN_W-1:0]   fin_cyc_i,
  output logic               done_o
);
  localparam int BURST_SH = $clog2(BURST_BYTES);
  localparam int CNT_W    = LEN_W - BURST_SH + 1;
  localparam int OVH_W    = $clog2(OVH_CYC + 2);
  localparam int CW       = (DRAIN_W > OVH_W) ? DRAIN_W : OVH_W;

  seq_state_e         state_q;
  logic [CW-1:0]      cnt_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [CNT_W-1:0]   left_q;
  logic [DRAIN_W-1:0] gap_q;

  logic [CNT_W-1:0]   n_chunks_c;
  logic [DRAIN_W-1:0] gap_c;
  logic [FIN_W-1:0]   fin_rem;
  logic               fin_expire;
  logic               fin_upd;

  rcs_plan #(
    .LEN_W(LEN_W), .DRAIN_W(DRAIN_W), .BURST_BYTES(BURST_BYTES), .CNT_W(CNT_W)
  ) u_plan (
    .cmd_len_i (cmd_len_i),
    .req_len_i (req_len_i),
    .drain_i   (drain_cyc_i),
    .n_chunks_o(n_chunks_c),
    .gap_o     (gap_c)
  );

  assign fin_upd = (state_q == ST_REPLY) && fin_valid_i;

  rcs_fin_track #(.FIN_W(FIN_W)) u_fin (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_IDLE),
    .upd_i   (fin_upd),
    .fin_i   (fin_cyc_i),
    .rem_o   (fin_rem),
    .expire_o(fin_expire)
  );

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign chk_valid_o = (state_q == ST_ISSUE);
  assign chk_addr_o  = addr_q;
  assign chk_wr_o    = 1'b0;
  assign done_o      = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      left_q  <= '0;
      gap_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cmd_valid_i) begin
          addr_q <= cmd_addr_i;
          left_q <= n_chunks_c;
          gap_q  <= gap_c;
          if (OVH_CYC != 0) begin
            state_q <= ST_OVH;
            cnt_q   <= CW'(OVH_CYC);
          end else if (n_chunks_c == '0) begin
            state_q <= ST_DONE;
          end else if (gap_c != '0) begin
            state_q <= ST_GAP;
            cnt_q   <= CW'(gap_c);
          end else begin
            state_q <= ST_ISSUE;
          end
        end
        ST_OVH: begin
          if (cnt_q <= CW'(1)) begin
            if (left_q == '0) state_q <= ST_DONE;
            else if (gap_q != '0) begin
              state_q <= ST_GAP;
              cnt_q   <= CW'(gap_q);
            end else state_q <= ST_ISSUE;
          end else cnt_q <= cnt_q - CW'(1);
        end
        ST_GAP: begin
          if (cnt_q <= CW'(1)) state_q <= ST_ISSUE;
          else                 cnt_q   <= cnt_q - CW'(1);
        end
        ST_ISSUE: state_q <= ST_REPLY;
        ST_REPLY: if (fin_valid_i) begin
          addr_q <= addr_q + ADDR_W'(BURST_BYTES);
          left_q <= left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) state_q <= ST_DRAIN;
          else if (gap_q != '0) begin
            state_q <= ST_GAP;
            cnt_q   <= CW'(gap_q);
          end else state_q <= ST_ISSUE;
        end
        ST_DRAIN: if (fin_expire) state_q <= ST_DONE;
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_accept_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && cmd_ready_o));

  assert_done_drained_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fin_rem == '0));

  assert_chunk_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o |=> !chk_valid_o);

  assert_chunk_left_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_valid_o |-> (left_q != '0));
endmodule

// File: tb/read_chunk_seq_tb.sv
`timescale 1ns/1ps
module read_chunk_seq_tb;
  localparam int AW = 40, LW = 24, DW = 16, FW = 16, BB = 256, OVH = 3;

  logic          clk = 1'b0, rst_ni = 1'b0;
  logic          cmd_valid = 1'b0, cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [LW-1:0] cmd_len = '0, req_len = '0;
  logic [DW-1:0] drain = '0;
  logic          chk_valid, chk_wr, done;
  logic [AW-1:0] chk_addr;
  logic          fin_valid = 1'b0;
  logic [FW-1:0] fin_cyc = '0;

  int cyc = 0;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  read_chunk_seq u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_addr_i(cmd_addr), .cmd_len_i(cmd_len), .req_len_i(req_len),
    .drain_cyc_i(drain),
    .chk_valid_o(chk_valid), .chk_addr_o(chk_addr), .chk_wr_o(chk_wr),
    .fin_valid_i(fin_valid), .fin_cyc_i(fin_cyc),
    .done_o(done)
  );

  function automatic longint lmax(longint a, longint b);
    return (a > b) ? a : b;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic poll_chunk(output bit got);
    got = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (chk_valid) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic poll_done(output bit got, output int extra);
    got = 1'b0; extra = 0;
    for (int k = 0; k < 3000; k++) begin
      if (done) begin got = 1'b1; break; end
      if (chk_valid) extra++;
      @(negedge clk);
    end
  endtask

  // one command; reply to each chunk one cycle after it is issued
  task automatic run_cmd(string dtag, longint base, longint clen, longint rlen,
                         longint dr, longint fin0, longint finr);
    longint work, n, gap, p, r, exp_at, done_exp, last_r, f;
    bit got;
    int extra;
    work = (clen != 0) ? clen : rlen;
    n    = (work + BB - 1) / BB;
    gap  = (dr == 0 || n == 0) ? 0 : ((dr / n == 0) ? 1 : dr / n);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R10", "ready before command", cmd_ready, 1);
    cmd_addr = AW'(base); cmd_len = LW'(clen); req_len = LW'(rlen); drain = DW'(dr);
    cmd_valid = 1'b1;
    @(posedge clk); #1;
    p = cyc; cmd_valid = 1'b0;
    @(negedge clk);
    exp_at = p + OVH + gap; done_exp = 0; last_r = 0;
    for (longint k = 0; k < n; k++) begin
      poll_chunk(got);
      if (!got) begin
        check(1'b0, (clen == 0) ? "R2" : "R3", "chunk count", k, n);
        return;
      end
      check(cyc == exp_at, (k == 0) ? "R6" : "R7", "chunk cycle", cyc, exp_at);
      check(chk_addr == AW'(base + k * BB), "R5", "chunk address", chk_addr, base + k * BB);
      check(chk_wr == 1'b0, "R5", "chunk direction", chk_wr, 0);
      check(cmd_ready == 1'b0, "R10", "ready while busy", cmd_ready, 0);
      f = (k == 0) ? fin0 : finr;
      @(posedge clk); #1;
      fin_valid = 1'b1; fin_cyc = FW'(f);
      @(posedge clk); #1;
      r = cyc; fin_valid = 1'b0;
      done_exp = lmax(done_exp, r + f); last_r = r; exp_at = r + gap;
      @(negedge clk);
    end
    if (n == 0) done_exp = p + OVH;
    else        done_exp = lmax(done_exp, last_r + 1);
    poll_done(got, extra);
    check(got, dtag, "done seen", got, 1);
    check(cyc == done_exp, dtag, "done cycle", cyc, done_exp);
    check(extra == 0, (clen == 0) ? "R2" : "R3", "extra chunks", extra, 0);
    check(cmd_ready == 1'b0, "R10", "ready in done cycle", cmd_ready, 0);
    @(negedge clk);
    check(done == 1'b0, "R9", "done single pulse", done, 0);
    check(cmd_ready == 1'b1, "R10", "ready after done", cmd_ready, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(cmd_ready == 1'b1 && chk_valid == 1'b0 && done == 1'b0, "R1", "outputs in reset",
          {cmd_ready, chk_valid, done}, 3'b100);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && chk_valid == 1'b0 && done == 1'b0, "R1", "outputs after reset",
          {cmd_ready, chk_valid, done}, 3'b100);
  endtask

  task automatic t_stray_reply;
    @(negedge clk);
    fin_valid = 1'b1; fin_cyc = FW'(500);
    @(negedge clk);
    fin_valid = 1'b0;
    check(cmd_ready == 1'b1 && done == 1'b0 && chk_valid == 1'b0, "R8", "idle reply ignored",
          {cmd_ready, done, chk_valid}, 3'b100);
    run_cmd("R8", 64'h2000, 512, 0, 20, 2, 2);
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    run_cmd("R9", 64'h1000, 1024, 0, 40, 5, 5);     // R6 R7: 4 chunks, gap 10
    run_cmd("R9", 64'h30080, 0, 600, 7, 3, 3);      // R2: fallback length, 3 chunks, gap 2
    run_cmd("R9", 64'h8000, 2048, 77, 5, 1, 1);     // R7: gap floor of 1
    run_cmd("R9", 64'h500, 512, 0, 0, 4, 4);        // R7: zero drain, back to back
    run_cmd("R4", 64'h700, 0, 0, 30, 0, 0);         // R4: empty read
    run_cmd("R9", 64'h9000, 768, 0, 3, 40, 2);      // R9: first finish dominates
    run_cmd("R9", 64'hA000, 1, 0, 100, 0, 0);       // R3: one-byte read, one chunk
    t_stray_reply();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule